// File: doc/BRIEF.md
# High/Low Count Clock Divider

This block divides a fast input clock by a programmable ratio. The ratio is the sum of two separate counts, one for the high time and one for the low time, both given in input clock cycles. The output therefore has a duty cycle that the user picks directly. A common use is generating slower clocks or clock-like strobes where both the period and the pulse width matter.

An odd-division option delays the rising edge of the output by half an input period. With a high count one greater than the low count, an odd ratio then gives an even 50 percent duty cycle. A bypass control passes the input clock straight through and overrides both counts and the odd option. New counts and the odd option are captured only when a new output period begins, so a period already under way always finishes with the settings it started with.

The control is a three-state machine on the rising edge of the input clock. ST_IDLE holds during reset. ST_IDLE goes to ST_HIGH on the first rising edge after reset and captures the configuration. ST_HIGH stays in ST_HIGH while the remaining count is above 1, and moves to ST_LOW when the count is 1. ST_LOW stays in ST_LOW while the remaining count is above 1, and returns to ST_HIGH when the count is 1, capturing the configuration again. A falling-edge register is ANDed with the high flag to make the half-period delay.

Top module: `hlc_divider`

## Requirements
- R1: With the odd option and bypass off, the output is high for exactly high_cnt input cycles and then low for exactly low_cnt cycles, so the period is high_cnt + low_cnt cycles. Each level changes just after a rising edge of clk_in.
- R2: A count field of 0 is treated as 256 cycles, for both the high count and the low count.
- R3: high_cnt, low_cnt and odd_half are sampled only at the rising edge that starts a high phase. A change made in the middle of a period takes effect at the start of the next period.
- R4: With odd_half set, the rising edge of the output comes half an input period later, on the falling edge of clk_in, while the falling edge stays where it was. The high time is high_cnt - 0.5 cycles and the low time is low_cnt + 0.5 cycles, so counts 2 and 1 give 1.5 and 1.5 cycles.
- R5: While bypass is 1 and reset is released, clk_out equals clk_in at once. This holds whatever the counts and the odd option are.
- R6: While rst_n is 0, clk_out is 0, even with bypass set. The first rising edge after release starts a high phase.
- R7: The count sequence keeps running while bypass is 1. When bypass returns to 0, the output resumes at the phase it would have reached without the bypass.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_in | input | 1 | Fast input clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| high_cnt | input | 8 | High time in input cycles, 0 means 256 |
| low_cnt | input | 8 | Low time in input cycles, 0 means 256 |
| bypass | input | 1 | 1 passes clk_in straight to the output |
| odd_half | input | 1 | 1 delays the rising edge by half an input cycle |
| clk_out | output | 1 | Divided clock |

## Verification
A wrong remaining count or a wrong state changes the position of the next output edge. That shows up within one output period as a high or low time of the wrong length. A stale or early capture of the counts shows in the first period after a change in the middle of a period. A wrong half-period register shows at once as a level that is wrong during the first or second half of an input cycle. For this reason the bench samples the output in both halves of every input cycle and compares it with an arithmetic phase model.

// File: rtl/hlc_pkg.sv
`timescale 1ns/1ps
package hlc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HIGH = 2'd1,
        ST_LOW  = 2'd2
    } phase_t;
endpackage

// File: rtl/hlc_phase_fsm.sv
`timescale 1ns/1ps
module hlc_phase_fsm
    import hlc_pkg::*;
#(
    parameter int CNT_W = 8,
    localparam int LEN_W = CNT_W + 1
) (
    input  logic             clk_in,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] high_cnt,
    input  logic [CNT_W-1:0] low_cnt,
    input  logic             odd_half,
    output logic             high_q,
    output logic             odd_q,
    output phase_t           phase_st,
    output logic [LEN_W-1:0] rem_cnt,
    output logic [LEN_W-1:0] lo_len
);
    phase_t           nxt_st;
    logic [LEN_W-1:0] cnt_nxt;
    logic [LEN_W-1:0] lo_nxt;
    logic             odd_nxt;
    logic             reload;

    function automatic logic [LEN_W-1:0] widen(input logic [CNT_W-1:0] v);
        if (v == '0)
            return LEN_W'(1) << CNT_W;
        return {1'b0, v};
    endfunction

    // state register
    always_ff @(posedge clk_in or negedge rst_n) begin
        if (!rst_n) begin
            phase_st <= ST_IDLE;
            rem_cnt  <= '0;
            lo_len   <= '0;
            odd_q    <= 1'b0;
        end else begin
            phase_st <= nxt_st;
            rem_cnt  <= cnt_nxt;
            lo_len   <= lo_nxt;
            odd_q    <= odd_nxt;
        end
    end

    // next state
    always_comb begin
        nxt_st  = phase_st;
        cnt_nxt = rem_cnt;
        lo_nxt  = lo_len;
        odd_nxt = odd_q;
        reload  = 1'b0;
        unique case (phase_st)
            ST_IDLE: reload = 1'b1;
            ST_HIGH: begin
                if (rem_cnt == LEN_W'(1)) begin
                    nxt_st  = ST_LOW;
                    cnt_nxt = lo_len;
                end else begin
                    cnt_nxt = rem_cnt - LEN_W'(1);
                end
            end
            ST_LOW: begin
                if (rem_cnt == LEN_W'(1))
                    reload = 1'b1;
                else
                    cnt_nxt = rem_cnt - LEN_W'(1);
            end
            default: nxt_st = ST_IDLE;
        endcase
        if (reload) begin
            nxt_st  = ST_HIGH;
            cnt_nxt = widen(high_cnt);
            lo_nxt  = widen(low_cnt);
            odd_nxt = odd_half;
        end
    end

    // output register
    always_ff @(posedge clk_in or negedge rst_n) begin
        if (!rst_n)
            high_q <= 1'b0;
        else
            high_q <= (nxt_st == ST_HIGH);
    end
endmodule

// File: rtl/hlc_half_shift.sv
`timescale 1ns/1ps
module hlc_half_shift (
    input  logic clk_in,
    input  logic rst_n,
    input  logic high_q,
    input  logic odd_q,
    output logic shaped
);
    logic late_q;

    always_ff @(negedge clk_in or negedge rst_n) begin
        if (!rst_n)
            late_q <= 1'b0;
        else
            late_q <= high_q;
    end

    assign shaped = odd_q ? (high_q & late_q) : high_q;
endmodule

// File: rtl/hlc_out_sel.sv
`timescale 1ns/1ps
module hlc_out_sel (
    input  logic clk_in,
    input  logic rst_n,
    input  logic bypass,
    input  logic shaped,
    output logic clk_out
);
    always_comb begin
        if (!rst_n)
            clk_out = 1'b0;
        else if (bypass)
            clk_out = clk_in;
        else
            clk_out = shaped;
    end
endmodule

// File: rtl/hlc_divider.sv
`timescale 1ns/1ps
module hlc_divider
    import hlc_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk_in,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] high_cnt,
    input  logic [CNT_W-1:0] low_cnt,
    input  logic             bypass,
    input  logic             odd_half,
    output logic             clk_out
);
    localparam int LEN_W = CNT_W + 1;

    logic             high_q;
    logic             odd_lat;
    logic             shaped;
    phase_t           phase_st;
    logic [LEN_W-1:0] rem_cnt;
    logic [LEN_W-1:0] lo_len;

    hlc_phase_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk_in   (clk_in),
        .rst_n    (rst_n),
        .high_cnt (high_cnt),
        .low_cnt  (low_cnt),
        .odd_half (odd_half),
        .high_q   (high_q),
        .odd_q    (odd_lat),
        .phase_st (phase_st),
        .rem_cnt  (rem_cnt),
        .lo_len   (lo_len)
    );

    hlc_half_shift u_shift (
        .clk_in (clk_in),
        .rst_n  (rst_n),
        .high_q (high_q),
        .odd_q  (odd_lat),
        .shaped (shaped)
    );

    hlc_out_sel u_sel (
        .clk_in  (clk_in),
        .rst_n   (rst_n),
        .bypass  (bypass),
        .shaped  (shaped),
        .clk_out (clk_out)
    );
endmodule

// File: rtl/hlc_divider_chk.sv
`timescale 1ns/1ps
module hlc_divider_chk
    import hlc_pkg::*;
#(
    parameter int CNT_W = 8,
    localparam int LEN_W = CNT_W + 1
) (
    input logic             clk_in,
    input logic             rst_n,
    input logic             bypass,
    input logic             clk_out,
    input phase_t           phase_st,
    input logic [LEN_W-1:0] rem_cnt,
    input logic [LEN_W-1:0] lo_len,
    input logic             odd_lat
);
    AST_HIGH_TO_LOW: assert property (@(posedge clk_in) disable iff (!rst_n)
        (phase_st == ST_HIGH && rem_cnt == LEN_W'(1)) |=> (phase_st == ST_LOW && rem_cnt == $past(lo_len))); // R1

    AST_LOW_TO_HIGH: assert property (@(posedge clk_in) disable iff (!rst_n)
        (phase_st == ST_LOW && rem_cnt == LEN_W'(1)) |=> (phase_st == ST_HIGH)); // R1

    AST_COUNT_LIVE: assert property (@(posedge clk_in) disable iff (!rst_n)
        (phase_st != ST_IDLE) |-> (rem_cnt != '0)); // R2

    AST_CFG_HELD: assert property (@(posedge clk_in) disable iff (!rst_n)
        (phase_st == ST_HIGH || (phase_st == ST_LOW && rem_cnt != LEN_W'(1))) |=> ($stable(lo_len) && $stable(odd_lat))); // R3

    AST_BYPASS_FOLLOW: assert property (@(negedge clk_in) disable iff (!rst_n)
        bypass |-> clk_out); // R5

    AST_IDLE_EXIT: assert property (@(posedge clk_in) disable iff (!rst_n)
        (phase_st == ST_IDLE) |=> (phase_st == ST_HIGH)); // R6

    always @(negedge clk_in) begin
        if (rst_n === 1'b0)
            AST_RESET_LOW: assert (clk_out === 1'b0); // R6
    end
endmodule

bind hlc_divider hlc_divider_chk #(.CNT_W(CNT_W)) u_chk (
    .clk_in   (clk_in),
    .rst_n    (rst_n),
    .bypass   (bypass),
    .clk_out  (clk_out),
    .phase_st (phase_st),
    .rem_cnt  (rem_cnt),
    .lo_len   (lo_len),
    .odd_lat  (odd_lat)
);

// File: tb/sim_hlc_divider.sv
`timescale 1ns/1ps
module sim_hlc_divider;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] hc = 8'd1;
    logic [7:0] lc = 8'd1;
    logic       byp = 1'b0;
    logic       odd = 1'b0;
    logic       clk_out;

    int  n_vec = 0;
    int  n_bad = 0;
    bit  done = 1'b0;
    bit  running = 1'b0;
    int  p = 0;
    int  hi_e = 1;
    int  lo_e = 1;
    bit  odd_e = 1'b0;

    always #2.5 clk = ~clk;

    hlc_divider u0 (
        .clk_in   (clk),
        .rst_n    (rst_n),
        .high_cnt (hc),
        .low_cnt  (lc),
        .bypass   (byp),
        .odd_half (odd),
        .clk_out  (clk_out)
    );

    task automatic check(input logic got, input logic exp, input string req);
        n_vec++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: clk_out=%b expected %b at %0t (hi=%0d lo=%0d odd=%0b p=%0d)",
                     req, got, exp, $time, hi_e, lo_e, odd_e, p);
        end
    endtask

    task automatic load_cfg();
        hi_e  = (hc == 8'd0) ? 256 : int'(hc);
        lo_e  = (lc == 8'd0) ? 256 : int'(lc);
        odd_e = odd;
    endtask

    // one input cycle: model step at the rising edge, then sample both halves
    task automatic tick(input string req);
        logic e1, e2;
        @(posedge clk);
        if (!rst_n) begin
            running = 1'b0;
        end else if (!running) begin
            running = 1'b1;
            p = 0;
            load_cfg();
        end else begin
            p++;
            if (p == hi_e + lo_e) begin
                p = 0;
                load_cfg();
            end
        end
        #1;
        if (!rst_n)      e1 = 1'b0;
        else if (byp)    e1 = 1'b1;
        else if (odd_e)  e1 = (p >= 1 && p < hi_e);
        else             e1 = (p < hi_e);
        check(clk_out, e1, req);
        #2.5;
        if (!rst_n)      e2 = 1'b0;
        else if (byp)    e2 = 1'b0;
        else             e2 = (p < hi_e);
        check(clk_out, e2, req);
    endtask

    task automatic restart(input int h, input int l, input bit o);
        rst_n = 1'b0;
        tick("R6");
        tick("R6");
        hc  = 8'(h);
        lc  = 8'(l);
        odd = o;
        rst_n = 1'b1;
    endtask

    initial begin
        // R6: output held low in reset, even with bypass requested
        byp = 1'b1;
        tick("R6");
        tick("R6");
        byp = 1'b0;

        // R1 and R4: sweep of small high/low counts, odd option off and on
        for (int o = 0; o < 2; o++) begin
            for (int h = 1; h <= 6; h++) begin
                for (int l = 1; l <= 6; l++) begin
                    restart(h, l, o[0]);
                    for (int k = 0; k < 2 * (h + l) + 1; k++)
                        tick(o == 0 ? "R1" : "R4");
                end
            end
        end

        // R4: divide by 3 with the odd option gives 1.5 / 1.5
        restart(2, 1, 1'b1);
        for (int k = 0; k < 9; k++) tick("R4");

        // R2: zero counts mean 256
        restart(0, 2, 1'b0);
        for (int k = 0; k < 2 * 258 + 2; k++) tick("R2");
        restart(3, 0, 1'b1);
        for (int k = 0; k < 2 * 259 + 2; k++) tick("R2");

        // R3: change during high phase, then during low phase
        restart(3, 2, 1'b0);
        tick("R3");
        tick("R3");
        hc = 8'd1; lc = 8'd4; odd = 1'b1;
        for (int k = 0; k < 8; k++) tick("R3");
        hc = 8'd4; lc = 8'd2; odd = 1'b0;
        for (int k = 0; k < 16; k++) tick("R3");

        // R5 and R7: bypass overrides, counter keeps its phase underneath
        restart(4, 3, 1'b0);
        for (int k = 0; k < 5; k++) tick("R5");
        byp = 1'b1;
        hc = 8'd0; odd = 1'b1;
        for (int k = 0; k < 7; k++) tick("R5");
        hc = 8'd4; odd = 1'b0;
        for (int k = 0; k < 3; k++) tick("R5");
        byp = 1'b0;
        for (int k = 0; k < 14; k++) tick("R7");

        // R6: reset in the middle of a high phase restarts a high phase
        restart(5, 5, 1'b0);
        for (int k = 0; k < 3; k++) tick("R6");
        restart(5, 5, 1'b0);
        for (int k = 0; k < 12; k++) tick("R6");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        #500000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not complete, actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule